// File: doc/BRIEF.md
# Programmable Interlaced Field Line Counter

This block tracks where the scan sits inside an interlaced field by counting half-line positions. It counts the blanking reference strobes that the horizontal timing chain issues at twice the line rate. A programmable selection word stands in for a wired jumper matrix. It chooses which count bits are gated together into one common group-reset detect, so the same logic serves several scan rates.

When every selected bit of the count is 1, the detect fires. On that strobe all counter stages are cleared together. The block then raises a vertical start trigger for one full strobe period. That trigger is what a downstream stage uses to begin the vertical interval.

If the number of counted positions per frame is odd, consecutive fields start half a line apart, which gives 2:1 interlace. A selection word of zero turns the group reset off, and the counter then runs round its full binary range.

Top module: `field_line_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next cycle shows `line_count` = 0 and `vstart` = 0.
- R2: Each clock cycle with `ref_strobe` high advances `line_count` by exactly one, unless R4 applies. Cycles with `ref_strobe` low leave `line_count` and `vstart` unchanged, however many such cycles pass between strobes.
- R3: The detect fires when `term_sel` is nonzero and `line_count` has a 1 in every bit position where `term_sel` has a 1. Count bits whose select bit is 0 have no effect on the detect.
- R4: A strobe that arrives while the detect fires clears every bit of `line_count` to 0 in the same cycle. The count does not advance on that strobe.
- R5: `vstart` goes high on the clearing strobe of R4. It stays high until the next strobe drops it, so it lasts exactly one strobe period, and `line_count` reads 0 for as long as `vstart` is high.
- R6: The first strobe after the clearing strobe brings `line_count` to 1, so one cycle of the field covers (terminal value + 1) strobes.
- R7: With `term_sel` = 0 the group reset is disabled: `line_count` wraps from 2047 to 0 on a plain strobe and `vstart` never goes high.
- R8: With `term_sel` = 524 (bits 9, 3 and 2 set), successive rising edges of `vstart` are exactly 525 strobes apart. That odd number of half-line positions per frame is what interlace needs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_strobe | input | 1 | One-cycle pulse per twice-line-rate blanking reference edge |
| term_sel | input | 11 | Count bits gated into the group-reset detect; zero disables it |
| line_count | output | 11 | Current half-line position in the field |
| vstart | output | 1 | Vertical start trigger, high for one strobe period after the group reset |

## Verification
The assertions assume that `ref_strobe` is a synchronous pulse in the `clk` domain. They also assume that `term_sel` changes only while no strobe is due, so a strobe never sees the selection change in the same cycle. The bench drives each strobe high for a single cycle at a falling edge, with at least one idle cycle after it. It changes `term_sel` only while reset is applied or between strobes. Gaps of different lengths between strobes show that the count and the trigger depend on strobe events alone and not on clock cycles.

// File: rtl/flc_pkg.sv
package flc_pkg;

    // Default counter width for the field counter
    localparam int FLC_CNT_W = 11;

    // Detect state carried from the group decode to the reset pulse logic
    typedef struct packed {
        logic enabled;   // at least one bit selected
        logic hit;       // every selected bit is one
    } flc_detect_t;

    // Build the detect result from the per-bit match terms
    function automatic flc_detect_t flc_make_detect(input logic any_sel, input logic all_match);
        flc_detect_t d;
        d.enabled = any_sel;
        d.hit     = any_sel & all_match;
        return d;
    endfunction

endpackage

// File: rtl/flc_stage_counter.sv
module flc_stage_counter #(
    parameter int CNT_W = flc_pkg::FLC_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    input  logic             group_clr,
    output logic [CNT_W-1:0] q
);
    // carry[i] is high when stage i must toggle
    logic [CNT_W:0] carry;

    assign carry[0] = advance & ~group_clr;

    for (genvar i = 0; i < CNT_W; i++) begin : g_stage
        logic bit_q;

        // Each stage acts like a toggle flip-flop with a common clear
        always_ff @(posedge clk) begin
            if (rst || group_clr) begin
                bit_q <= 1'b0;
            end else if (carry[i]) begin
                bit_q <= ~bit_q;
            end
        end

        assign carry[i+1] = carry[i] & bit_q;
        assign q[i]       = bit_q;
    end
endmodule

// File: rtl/flc_group_decode.sv
module flc_group_decode #(
    parameter int CNT_W = flc_pkg::FLC_CNT_W
) (
    input  logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  sel,
    output flc_pkg::flc_detect_t detect
);
    // A bit passes when it is not selected or when it is set
    logic [CNT_W-1:0] pass_term;

    for (genvar i = 0; i < CNT_W; i++) begin : g_term
        assign pass_term[i] = ~sel[i] | count[i];
    end

    assign detect = flc_pkg::flc_make_detect(|sel, &pass_term);
endmodule

// File: rtl/flc_reset_pulse.sv
module flc_reset_pulse (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 strobe,
    input  flc_pkg::flc_detect_t detect,
    output logic                 group_clr,
    output logic                 trig
);
    // Clear all stages on the strobe that sees the detect
    assign group_clr = strobe & detect.hit;

    // Trigger spans from the clearing strobe to the following strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            trig <= 1'b0;
        end else if (strobe) begin
            trig <= detect.hit;
        end
    end
endmodule

// File: rtl/field_line_counter.sv
module field_line_counter #(
    parameter int CNT_W = flc_pkg::FLC_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_strobe,
    input  logic [CNT_W-1:0] term_sel,
    output logic [CNT_W-1:0] line_count,
    output logic             vstart
);
    flc_pkg::flc_detect_t detect;
    logic                 group_clr;

    flc_stage_counter #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .advance   (ref_strobe),
        .group_clr (group_clr),
        .q         (line_count)
    );

    flc_group_decode #(.CNT_W(CNT_W)) u_decode (
        .count  (line_count),
        .sel    (term_sel),
        .detect (detect)
    );

    flc_reset_pulse u_pulse (
        .clk       (clk),
        .rst       (rst),
        .strobe    (ref_strobe),
        .detect    (detect),
        .group_clr (group_clr),
        .trig      (vstart)
    );
endmodule

// File: rtl/flc_checker.sv
module flc_checker #(
    parameter int CNT_W = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             ref_strobe,
    input logic [CNT_W-1:0] term_sel,
    input logic [CNT_W-1:0] line_count,
    input logic             vstart
);
    logic [CNT_W-1:0] cnt_plus;
    logic             sel_full;

    assign cnt_plus = line_count + 1'b1;
    assign sel_full = (term_sel != '0) && ((line_count & term_sel) == term_sel);

    // R2
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !ref_strobe |=> ($stable(line_count) && $stable(vstart)));

    // R2
    advance_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_strobe && !sel_full) |=> (line_count == $past(cnt_plus) && !vstart));

    // R4
    group_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_strobe && sel_full) |=> (line_count == '0 && vstart));

    // R5
    trig_zero_chk: assert property (@(posedge clk) disable iff (rst)
        vstart |-> (line_count == '0));

    // R7
    no_trig_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_strobe && term_sel == '0) |=> !vstart);
endmodule

bind field_line_counter flc_checker #(.CNT_W(CNT_W)) u_flc_checker (
    .clk        (clk),
    .rst        (rst),
    .ref_strobe (ref_strobe),
    .term_sel   (term_sel),
    .line_count (line_count),
    .vstart     (vstart)
);

// File: tb/test_field_line_counter.sv
`timescale 1ns/1ps
module test_field_line_counter;
    localparam int W = 11;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ref_strobe = 1'b0;
    logic [W-1:0] term_sel = '0;
    logic [W-1:0] line_count;
    logic         vstart;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    int unsigned m_cnt;
    bit          m_trig;

    always #2 clk = ~clk;

    field_line_counter #(.CNT_W(W)) i_field_line_counter (
        .clk        (clk),
        .rst        (rst),
        .ref_strobe (ref_strobe),
        .term_sel   (term_sel),
        .line_count (line_count),
        .vstart     (vstart)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        ref_strobe = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_cnt  = 0;
        m_trig = 0;
    endtask

    // One strobe, followed by idle cycles; updates the model
    task automatic strobe(input int gap);
        @(negedge clk);
        ref_strobe = 1'b1;
        @(negedge clk);
        ref_strobe = 1'b0;
        if (term_sel != '0 && ((m_cnt[W-1:0] & term_sel) == term_sel)) begin
            m_cnt  = 0;
            m_trig = 1;
        end else begin
            m_cnt  = (m_cnt + 1) % (1 << W);
            m_trig = 0;
        end
        for (int k = 0; k < gap; k++) @(negedge clk);
    endtask

    task automatic t_reset();
        term_sel = 11'd5;
        apply_reset();
        check(line_count == 0, "R1 count", line_count, 0);
        check(vstart == 0, "R1 vstart", vstart, 0);
    endtask

    task automatic t_count_gaps();
        term_sel = '0;
        apply_reset();
        for (int i = 0; i < 6; i++) begin
            strobe(i);
            check(line_count == m_cnt, "R2 count", line_count, m_cnt);
        end
        for (int i = 0; i < 5; i++) @(negedge clk);
        check(line_count == 6, "R2 idle hold", line_count, 6);
    endtask

    task automatic t_mask5();
        int trig_seen = 0;
        term_sel = 11'd5;
        apply_reset();
        for (int i = 0; i < 14; i++) begin
            strobe(1);
            check(line_count == m_cnt, "R3/R4 count", line_count, m_cnt);
            check(vstart == m_trig, "R5 vstart", vstart, m_trig);
            if (m_trig) begin
                trig_seen++;
                for (int k = 0; k < 4; k++) @(negedge clk);
                check(vstart == 1 && line_count == 0, "R5 held through gap", vstart, 1);
                strobe(1);
                check(line_count == 1, "R6 resume", line_count, 1);
                check(vstart == 0, "R5 one period", vstart, 0);
            end
        end
        check(trig_seen == 2, "R4 trigger count", trig_seen, 2);
    endtask

    task automatic t_mask4();
        int first = -1;
        term_sel = 11'd4;
        apply_reset();
        for (int i = 1; i <= 12; i++) begin
            strobe(1);
            if (vstart && first < 0) first = i;
        end
        // count reaches 4 after 4 strobes, clear on strobe 5; bits 0,1 ignored
        check(first == 5, "R3 unselected bits ignored", first, 5);
    endtask

    task automatic t_wrap();
        bit any_trig = 0;
        term_sel = '0;
        apply_reset();
        for (int i = 0; i < 2047; i++) begin
            strobe(0);
            if (vstart) any_trig = 1;
        end
        check(line_count == 2047, "R7 top", line_count, 2047);
        strobe(0);
        check(line_count == 0, "R7 wrap", line_count, 0);
        check(vstart == 0 && any_trig == 0, "R7 no trigger", vstart, 0);
        strobe(0);
        check(line_count == 1, "R7 after wrap", line_count, 1);
    endtask

    task automatic t_interlace();
        int last = -1;
        int n_edges = 0;
        bit prev = 0;
        term_sel = 11'd524;
        apply_reset();
        for (int i = 1; i <= 1700; i++) begin
            strobe(0);
            if (vstart && !prev) begin
                if (last >= 0) begin
                    check(i - last == 525, "R8 spacing", i - last, 525);
                end
                last = i;
                n_edges++;
            end
            prev = vstart;
        end
        check(n_edges == 3, "R8 edge count", n_edges, 3);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_count_gaps();
        t_mask5();
        t_mask4();
        t_wrap();
        t_interlace();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule